// File: doc/BRIEF.md
# Quad SPI Sequencer Register Front End

This block is the processor-facing register file of a quad SPI sequencer. A single-cycle bus reaches a control word, a frame descriptor split across two registers, an interrupt mask and a status word. The same bus reaches a transmit byte FIFO and a receive byte FIFO. The serial engine behind the block is modelled as a byte stream in each direction, plus done strobes. The engine reads its configuration from the `ctrl_o`, `total_bytes_o`, `cmd_bytes_o`, `idle_cycles_o` and `frame_flags_o` outputs. It starts work when `frame_start_o` pulses.

Software can move FIFO data through narrow ports, one byte per access in bits [7:0]. When the packed-access flag is set in control bit 16, it can also use wide ports that move four bytes per access, with the lowest byte first. Event bits in the status word are sticky and cleared by writing 1. Fill-level bits in the status word follow the FIFOs directly. `irq_o` is a level signal: the OR of each status bit in [5:0] ANDed with its mask bit.

Read data is combinational and appears in the same cycle as the request. A read of a receive port removes the data it returns at the clock edge that ends the request.

Top module: `qspi_csr_front`

## Requirements
- R1: After reset, control, frames, upper count and interrupt mask read 0. Status reads 0x98 (bits 3, 4 and 7 set) and `irq_o` is low.
- R2: Control (0x00) and frames (0x04) read back what was written. The mask (0x0C) keeps `wdata_i[5:0]`. The upper count (0x50) keeps `wdata_i[31:16]` and reads it back in the same position. `total_bytes_o` is {upper, frames[15:0]}. `cmd_bytes_o` is frames[24:16] and `idle_cycles_o` is frames[29:26]. `frame_flags_o` is {frames[31], frames[30], frames[25]}.
- R3: A write to 0x44 appends `wdata_i[7:0]` to the 16-byte transmit FIFO, and the write is dropped when that FIFO is full. Bytes leave on `tx_data_o`/`tx_valid_o` in order, one per cycle with `tx_ready_i` high.
- R4: With control bit 16 set, a write to 0x4C appends bits [7:0], [15:8], [23:16] and [31:24] in that order. The write is accepted only if at least 4 entries are free, otherwise it is dropped entirely. With bit 16 clear, writes to 0x4C are ignored.
- R5: A read of 0x40 returns the oldest received byte in bits [7:0], with zeros above, and removes it. On an empty receive FIFO it returns 0 and removes nothing.
- R6: With control bit 16 set, a read of 0x48 returns the four oldest received bytes, oldest in [7:0], and removes them. It returns 0 and removes nothing when fewer than 4 are held or when bit 16 is clear.
- R7: The status word at 0x10 is laid out as follows. Bit 3 is transmit FIFO not full, bit 4 is receive FIFO empty, bit 5 is transmit FIFO full, bit 7 is ready, and bit 8 mirrors control bit 16. Bit 6 and bits [31:9] read 0.
- R8: Bit 0 is set by `tx_done_i`. Bit 1 is set when a byte with `rx_last_i` is taken into the receive FIFO. Bit 2 is set every cycle the receive FIFO holds data. Writing 1 to bits [2:0] at 0x10 clears those bits and writing 0 does not. A set in the same cycle as a clear wins.
- R9: A write to 0x04 drives ready (status bit 7) low and pulses `frame_start_o` for one cycle after the write. `frame_done_i` returns ready high. A frames write in the same cycle as `frame_done_i` leaves ready low.
- R10: `irq_o` is high exactly when (status[5:0] & mask[5:0]) is nonzero.
- R11: A byte offered on `rx_valid_i` while the receive FIFO holds 16 bytes is discarded and does not set status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| ctrl_o | output | 32 | Control word to the sequencer |
| total_bytes_o | output | 32 | Total bytes in the frame |
| cmd_bytes_o | output | 9 | Bytes sent before read data is kept |
| idle_cycles_o | output | 4 | Dummy clocks between command and data |
| frame_flags_o | output | 3 | Frame descriptor flags {31,30,25} |
| frame_start_o | output | 1 | One-cycle pulse after a frames write |
| frame_done_i | input | 1 | Sequencer finished the frame |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_ready_i | input | 1 | Sequencer takes the transmit byte |
| tx_done_i | input | 1 | Transmit done event |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte offered |
| rx_last_i | input | 1 | Offered byte is the last of the frame |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions run on every cycle and check four things. Pushes and pops never exceed the free or held entries. A frames write always drops ready and raises the start pulse. A sticky event stays set until it is cleared by a write of 1. The receive-available bit is set while the receive FIFO holds data. Only the bench scenarios can show the byte order through the packed ports, which wide accesses are dropped or ignored, reads of empty FIFOs returning zero, the overflow discard, and the priority of set over clear. The bench model covers these with its own queues, and it compares interrupt, transmit stream, frame outputs and every read against that model on every clock.

// File: rtl/qspi_csr_pkg.sv
package qspi_csr_pkg;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_FRAMES = 'h04;
  localparam int unsigned OFS_MASK   = 'h0C;
  localparam int unsigned OFS_STAT   = 'h10;
  localparam int unsigned OFS_RXB    = 'h40;
  localparam int unsigned OFS_TXB    = 'h44;
  localparam int unsigned OFS_RXW    = 'h48;
  localparam int unsigned OFS_TXW    = 'h4C;
  localparam int unsigned OFS_UPPER  = 'h50;

  localparam int unsigned CTRL_WIDE_BIT = 16;
  localparam int unsigned CMD_LSB  = 16;
  localparam int unsigned CMD_MSB  = 24;
  localparam int unsigned IDLE_LSB = 26;
  localparam int unsigned IDLE_MSB = 29;
  localparam int unsigned EVT_W    = 3;
  localparam int unsigned MASK_W   = 6;
  localparam int unsigned STAT_W   = 9;
endpackage

// File: rtl/qspi_byte_fifo.sv
module qspi_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 4,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = PW + 1,
  localparam int unsigned NW = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NW-1:0]      push_n_i,
  input  logic [8*LANES-1:0] push_data_i,
  input  logic [NW-1:0]      pop_n_i,
  output logic [8*LANES-1:0] head_o,
  output logic [CW-1:0]      count_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < int'(LANES); k++) begin
      if (k < int'(push_n_i)) mem[wr_ptr + PW'(k)] <= push_data_i[8*k +: 8];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_head
    assign head_o[8*k +: 8] = mem[rd_ptr + PW'(k)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      wr_ptr  <= wr_ptr + PW'(push_n_i);
      rd_ptr  <= rd_ptr + PW'(pop_n_i);
      count_o <= count_o + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  // callers must gate by fill level
  assert_push_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_n_i != '0) |-> (CW'(push_n_i) <= CW'(DEPTH) - count_o));
  assert_pop_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_n_i != '0) |-> (CW'(pop_n_i) <= count_o));
endmodule

// File: rtl/qspi_evt_status.sv
module qspi_evt_status
  import qspi_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  clr_i,
  input  logic              tx_done_i,
  input  logic              rx_last_in_i,
  input  logic              rx_held_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              ready_i,
  input  logic              wide_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] evt_q, evt_set;

  assign evt_set = {rx_held_i, rx_last_in_i, tx_done_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i) | evt_set;
  end

  assign status_o = {wide_i, ready_i, 1'b0, tx_full_i, rx_empty_i, ~tx_full_i, evt_q};
  assign irq_o    = |(status_o[MASK_W-1:0] & mask_i);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q[0] && !clr_i[0]) |=> evt_q[0]);
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !tx_done_i) |=> !status_o[0]);
  assert_rx_avail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_empty_i |=> status_o[2]);
endmodule

// File: rtl/qspi_csr_front.sv
module qspi_csr_front
  import qspi_csr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  localparam int unsigned LANES = BUS_W / 8,
  localparam int unsigned CW    = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned NW    = $clog2(LANES + 1),
  localparam int unsigned HALF  = BUS_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [BUS_W-1:0]  ctrl_o,
  output logic [BUS_W-1:0]  total_bytes_o,
  output logic [8:0]        cmd_bytes_o,
  output logic [3:0]        idle_cycles_o,
  output logic [2:0]        frame_flags_o,
  output logic              frame_start_o,
  input  logic              frame_done_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              tx_done_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  output logic              irq_o
);
  logic [BUS_W-1:0]  ctrl_q, frames_q;
  logic [HALF-1:0]   upper_q;
  logic [MASK_W-1:0] mask_q;
  logic              ready_q, start_q;

  logic wr, rd, wide;
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign wide = ctrl_q[CTRL_WIDE_BIT];

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic frm_wr;
  assign frm_wr = wr && at(addr_i, OFS_FRAMES);

  // ---------------- FIFOs ----------------
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [NW-1:0]    tx_push, tx_pop, rx_push, rx_pop;
  logic [BUS_W-1:0] tx_head, rx_head;
  logic             tx_full, rx_full, rx_take;

  assign tx_full = tx_cnt == CW'(FIFO_DEPTH);
  assign rx_full = rx_cnt == CW'(FIFO_DEPTH);
  assign rx_take = rx_valid_i && !rx_full;

  always_comb begin
    tx_push = '0;
    if (wr && at(addr_i, OFS_TXB) && !tx_full)
      tx_push = NW'(1);
    else if (wr && at(addr_i, OFS_TXW) && wide &&
             (CW'(FIFO_DEPTH) - tx_cnt) >= CW'(LANES))
      tx_push = NW'(LANES);
  end
  assign tx_pop  = (tx_ready_i && tx_cnt != '0) ? NW'(1) : '0;
  assign rx_push = rx_take ? NW'(1) : '0;

  always_comb begin
    rx_pop = '0;
    if (rd && at(addr_i, OFS_RXB) && rx_cnt != '0)
      rx_pop = NW'(1);
    else if (rd && at(addr_i, OFS_RXW) && wide && rx_cnt >= CW'(LANES))
      rx_pop = NW'(LANES);
  end

  qspi_byte_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_tx_fifo (
    .clk_i, .rst_ni, .push_n_i(tx_push), .push_data_i(wdata_i),
    .pop_n_i(tx_pop), .head_o(tx_head), .count_o(tx_cnt)
  );

  qspi_byte_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_rx_fifo (
    .clk_i, .rst_ni, .push_n_i(rx_push), .push_data_i({{(BUS_W-8){1'b0}}, rx_data_i}),
    .pop_n_i(rx_pop), .head_o(rx_head), .count_o(rx_cnt)
  );

  logic unused_tx_hi;
  assign unused_tx_hi = ^tx_head[BUS_W-1:8];

  assign tx_data_o  = tx_head[7:0];
  assign tx_valid_o = tx_cnt != '0;

  // ---------------- registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      frames_q <= '0;
      upper_q  <= '0;
      mask_q   <= '0;
      ready_q  <= 1'b1;
      start_q  <= 1'b0;
    end else begin
      if (wr && at(addr_i, OFS_CTRL))  ctrl_q  <= wdata_i;
      if (frm_wr)                      frames_q <= wdata_i;
      if (wr && at(addr_i, OFS_UPPER)) upper_q <= wdata_i[BUS_W-1:HALF];
      if (wr && at(addr_i, OFS_MASK))  mask_q  <= wdata_i[MASK_W-1:0];
      start_q <= frm_wr;
      if (frm_wr)            ready_q <= 1'b0;
      else if (frame_done_i) ready_q <= 1'b1;
    end
  end

  // ---------------- status / interrupt ----------------
  logic [EVT_W-1:0]  clr;
  logic [STAT_W-1:0] status;

  assign clr = (wr && at(addr_i, OFS_STAT)) ? wdata_i[EVT_W-1:0] : '0;

  qspi_evt_status u_status (
    .clk_i, .rst_ni, .clr_i(clr), .tx_done_i,
    .rx_last_in_i(rx_take && rx_last_i), .rx_held_i(rx_cnt != '0),
    .tx_full_i(tx_full), .rx_empty_i(rx_cnt == '0), .ready_i(ready_q),
    .wide_i(wide), .mask_i(mask_q), .status_o(status), .irq_o
  );

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (at(addr_i, OFS_CTRL))   rdata_o = ctrl_q;
      if (at(addr_i, OFS_FRAMES)) rdata_o = frames_q;
      if (at(addr_i, OFS_MASK))   rdata_o = BUS_W'(mask_q);
      if (at(addr_i, OFS_STAT))   rdata_o = BUS_W'(status);
      if (at(addr_i, OFS_UPPER))  rdata_o = {upper_q, {HALF{1'b0}}};
      if (at(addr_i, OFS_RXB) && rx_cnt != '0)
        rdata_o = BUS_W'(rx_head[7:0]);
      if (at(addr_i, OFS_RXW) && wide && rx_cnt >= CW'(LANES))
        rdata_o = rx_head;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign total_bytes_o = {upper_q, frames_q[HALF-1:0]};
  assign cmd_bytes_o   = frames_q[CMD_MSB:CMD_LSB];
  assign idle_cycles_o = frames_q[IDLE_MSB:IDLE_LSB];
  assign frame_flags_o = {frames_q[31], frames_q[30], frames_q[25]};
  assign frame_start_o = start_q;

  assert_frame_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_wr |=> (frame_start_o && !ready_q));
  assert_done_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !frm_wr) |=> ready_q);
  assert_rx_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && rx_valid_i && rx_pop == '0) |=> rx_full);
endmodule

// File: tb/qspi_csr_front_tb.sv
module qspi_csr_front_tb;
  logic clk = 0, rst_ni = 0;
  always #5 clk = ~clk;

  logic        req = 0, we = 0, tx_ready = 0, tx_done = 0, rx_valid = 0, rx_last = 0, frame_done = 0;
  logic [7:0]  addr = 0, rx_data = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, ctrl, total;
  logic [8:0]  cmd;
  logic [3:0]  idle;
  logic [2:0]  flags;
  logic        fstart, tx_valid, irq;
  logic [7:0]  tx_data;

  qspi_csr_front u_dut (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ctrl_o(ctrl), .total_bytes_o(total), .cmd_bytes_o(cmd),
    .idle_cycles_o(idle), .frame_flags_o(flags), .frame_start_o(fstart),
    .frame_done_i(frame_done), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_done_i(tx_done), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_last_i(rx_last), .irq_o(irq)
  );

  // reference model state
  logic [31:0] m_ctrl = 0, m_frames = 0;
  logic [15:0] m_upper = 0;
  logic [5:0]  m_mask = 0;
  logic        m_ready = 1, m_start = 0, ev0 = 0, ev1 = 0, ev2 = 0;
  logic [7:0]  txq[$], rxq[$];
  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    return {23'd0, m_ctrl[16], m_ready, 1'b0, txq.size() == 16, rxq.size() == 0,
            txq.size() != 16, ev2, ev1, ev0};
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return m_frames;
      8'h0C: return {26'd0, m_mask};
      8'h10: return m_status();
      8'h50: return {m_upper, 16'd0};
      8'h40: return rxq.size() > 0 ? {24'd0, rxq[0]} : 32'd0;
      8'h48: return (m_ctrl[16] && rxq.size() >= 4) ? {rxq[3], rxq[2], rxq[1], rxq[0]} : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_update();
    int ntx = txq.size(), nrx = rxq.size();
    bit w = req && we, r = req && !we, take;
    logic [2:0] clr;
    if (tx_ready && ntx > 0) void'(txq.pop_front());
    if (w && addr == 8'h44 && ntx < 16) txq.push_back(wdata[7:0]);
    if (w && addr == 8'h4C && m_ctrl[16] && 16 - ntx >= 4)
      for (int k = 0; k < 4; k++) txq.push_back(wdata[8*k +: 8]);
    take = rx_valid && nrx < 16;
    if (r && addr == 8'h40 && nrx > 0) void'(rxq.pop_front());
    if (r && addr == 8'h48 && m_ctrl[16] && nrx >= 4)
      for (int k = 0; k < 4; k++) void'(rxq.pop_front());
    if (take) rxq.push_back(rx_data);
    clr = (w && addr == 8'h10) ? wdata[2:0] : 3'b0;
    ev0 = (ev0 && !clr[0]) || tx_done;
    ev1 = (ev1 && !clr[1]) || (take && rx_last);
    ev2 = (ev2 && !clr[2]) || (nrx != 0);
    if (w && addr == 8'h04) m_ready = 0; else if (frame_done) m_ready = 1;
    m_start = w && addr == 8'h04;
    if (w && addr == 8'h00) m_ctrl = wdata;
    if (w && addr == 8'h04) m_frames = wdata;
    if (w && addr == 8'h50) m_upper = wdata[31:16];
    if (w && addr == 8'h0C) m_mask = wdata[5:0];
  endtask

  task automatic step();
    #1;
    chk("R10", "irq", {31'd0, irq}, {31'd0, |(m_status() & {26'd0, m_mask})});
    chk(cur_tag, "tx_valid", {31'd0, tx_valid}, {31'd0, txq.size() != 0});
    if (txq.size() != 0) chk(cur_tag, "tx_data", {24'd0, tx_data}, {24'd0, txq[0]});
    chk("R9", "frame_start", {31'd0, fstart}, {31'd0, m_start});
    chk("R2", "total", total, {m_upper, m_frames[15:0]});
    chk("R2", "cmd/idle/flags", {16'd0, cmd, idle, flags},
        {16'd0, m_frames[24:16], m_frames[29:26], m_frames[31], m_frames[30], m_frames[25]});
    if (req && !we) chk(cur_tag, $sformatf("rd %h", addr), rdata, m_read(addr));
    @(posedge clk);
    model_update();
    @(negedge clk);
    req = 0; we = 0; addr = 0; wdata = 0; tx_ready = 0; tx_done = 0;
    rx_valid = 0; rx_last = 0; rx_data = 0; frame_done = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d; step();
  endtask
  task automatic rd(logic [7:0] a);
    req = 1; we = 0; addr = a; step();
  endtask
  task automatic rx_byte(logic [7:0] d, logic last);
    rx_valid = 1; rx_data = d; rx_last = last; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset values
    cur_tag = "R1";
    req = 1; addr = 8'h10; #1 chk("R1", "status literal", rdata, 32'h98);
    step();
    rd(8'h00); rd(8'h04); rd(8'h0C); rd(8'h50);
    // R2: register read-back
    cur_tag = "R2";
    wr(8'h00, 32'h0A00_2401); rd(8'h00);
    wr(8'h04, 32'h9E03_00A5); rd(8'h04);
    wr(8'h50, 32'hBEEF_1234); rd(8'h50);
    wr(8'h0C, 32'hFFFF_FFC5); rd(8'h0C);
    // R9: ready / start
    cur_tag = "R9";
    rd(8'h10); frame_done = 1; step(); rd(8'h10);
    frame_done = 1; wr(8'h04, 32'h0001_0010); rd(8'h10);
    frame_done = 1; step(); rd(8'h10);
    // R3: byte transmit
    cur_tag = "R3";
    wr(8'h0C, 32'h0);
    for (int i = 0; i < 5; i++) wr(8'h44, 32'hFFFF_FF00 | (i * 17));
    repeat (3) begin tx_ready = 1; step(); end
    tx_ready = 1; wr(8'h44, 32'h5A);
    repeat (4) begin tx_ready = 1; step(); end
    for (int i = 0; i < 17; i++) wr(8'h44, 32'h80 + i);
    rd(8'h10);
    repeat (17) begin tx_ready = 1; step(); end
    // R4: packed transmit
    cur_tag = "R4";
    wr(8'h00, 32'h0001_0000); rd(8'h10);
    wr(8'h4C, 32'h4433_2211);
    repeat (4) begin tx_ready = 1; step(); end
    for (int i = 0; i < 14; i++) wr(8'h44, 32'h30 + i);
    wr(8'h4C, 32'hDDCC_BBAA); rd(8'h10);
    repeat (15) begin tx_ready = 1; step(); end
    wr(8'h00, 32'h0); wr(8'h4C, 32'h1122_3344); rd(8'h10); step();
    // R5: byte receive, empty read
    cur_tag = "R5";
    rx_byte(8'hA1, 0); rx_byte(8'hB2, 0); rx_byte(8'hC3, 1);
    rd(8'h10);
    repeat (4) rd(8'h40);
    rd(8'h10);
    // R11: overflow discard
    cur_tag = "R11";
    wr(8'h10, 32'h7);
    for (int i = 0; i < 16; i++) rx_byte(8'h60 + i, 0);
    rx_byte(8'hEE, 1); rd(8'h10); rd(8'h40);
    // R6: packed receive (15 held)
    cur_tag = "R6";
    rd(8'h48);
    wr(8'h00, 32'h0001_0000);
    repeat (3) rd(8'h48);
    rd(8'h48); rd(8'h40); rd(8'h48); rd(8'h40); rd(8'h40); rd(8'h48); rd(8'h10);
    // R8: sticky events
    cur_tag = "R8";
    wr(8'h10, 32'h7); rd(8'h10);
    tx_done = 1; step(); wr(8'h10, 32'h0); rd(8'h10);
    wr(8'h10, 32'h1); rd(8'h10);
    rx_byte(8'h11, 0); step(); wr(8'h10, 32'h4); rd(8'h10);
    tx_done = 1; wr(8'h10, 32'h1); rd(8'h10);
    rx_valid = 1; rx_last = 1; rx_data = 8'h22; wr(8'h10, 32'h2); rd(8'h10);
    rd(8'h40); rd(8'h40); wr(8'h10, 32'h4); rd(8'h10);
    // R7: live bits
    cur_tag = "R7";
    for (int i = 0; i < 16; i++) wr(8'h44, i);
    rd(8'h10); wr(8'h00, 32'h0); rd(8'h10);
    repeat (16) begin tx_ready = 1; step(); end
    rd(8'h10);
    // R10: interrupt mask
    cur_tag = "R10";
    wr(8'h0C, 32'h10); step(); wr(8'h0C, 32'h01); step();
    tx_done = 1; step(); step(); wr(8'h0C, 32'h20); step();
    for (int i = 0; i < 16; i++) wr(8'h44, i);
    step(); wr(8'h0C, 32'h3F); step();
    finish_run();
  end
endmodule